// File: doc/BRIEF.md
# Buffered Input Capture Channel

This block stamps the value of a free-running timer into a capture register each time a chosen transition is seen on an asynchronous input pin. Behind the capture register is a holding register. A latch strobe, produced elsewhere by a periodic event or by software, moves a pending capture into the holding register. Between them, the two registers can keep two separate timestamps until software reads them.

Each register has its own full/empty state. A capture register empties when it is read or when its value moves into the holding register. The holding register empties only when it is read. A no-overwrite enable controls what happens when a capture arrives while the capture register still holds an unread value. With the enable clear, the new timestamp replaces the old one. With the enable set, the new capture is dropped. Each capture that is accepted sets a sticky flag, and writing 1 clears that flag.

Top module: `bic_channel`

## Requirements
- R1: After reset, cap_full, hold_full and cap_flag are 0, and cap_data and hold_data are 0.
- R2: edge_sel selects which pin transitions cause a capture: 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 both. A transition that is not selected leaves cap_data, cap_full and cap_flag unchanged.
- R3: The pin passes through a two-stage synchronizer. A pin change made before clock edge 1 is captured at clock edge 3, using the timer_cnt value present at that edge. The result is visible after edge 3 and not after edge 2.
- R4: A latch_stb cycle with cap_full=1 copies cap_data into hold_data, sets hold_full and clears cap_full.
- R5: A latch_stb cycle with cap_full=0 leaves hold_data and hold_full unchanged.
- R6: A cap_rd cycle clears cap_full. A hold_rd cycle clears hold_full and leaves cap_full unchanged. Only a read clears hold_full.
- R7: With novw_en=0, an accepted edge always writes timer_cnt into the capture register, even when cap_full=1.
- R8: With novw_en=1, a capture that arrives while cap_full=1 is dropped: cap_data is unchanged and cap_flag is not set. A capture that arrives while cap_full=0 is accepted.
- R9: When a cap_rd and a capture fall in the same cycle, cap_data shows the old value during that cycle. Afterwards it holds the new capture, with cap_full=1.
- R10: Each accepted capture sets cap_flag. A flag_clr cycle clears it. When a capture and flag_clr fall in the same cycle, the flag stays set.
- R11: When latch_stb and a capture fall in the same cycle while cap_full=1, the holding register receives the old capture and the capture register receives the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_cnt | input | TW | Free-running timer value |
| pin_in | input | 1 | Asynchronous capture input |
| edge_sel | input | 2 | Edge selection (R2 encoding) |
| novw_en | input | 1 | No-overwrite enable |
| latch_stb | input | 1 | One-cycle latch event |
| cap_rd | input | 1 | Read strobe, capture register |
| hold_rd | input | 1 | Read strobe, holding register |
| flag_clr | input | 1 | Write-1 clear of cap_flag |
| cap_data | output | TW | Capture register |
| hold_data | output | TW | Holding register |
| cap_full | output | 1 | Capture register holds an unread value |
| hold_full | output | 1 | Holding register holds an unread value |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The assertions assume the strobes (latch_stb, cap_rd, hold_rd, flag_clr) each last one cycle per event. They also assume edge_sel and novw_en change only while the synchronized pin is quiet, so a detected edge is always judged against the settings that were in force when it arrived. The stimulus drives every input at the falling clock edge and keeps timer_cnt constant from each pin change until its capture. It also waits for the synchronizer to settle before changing edge_sel or novw_en.

// File: rtl/bic_pkg.sv
package bic_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

endpackage

// File: rtl/bic_edge_detect.sv
module bic_edge_detect
    import bic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  edge_mode_e edge_sel,
    output logic       hit
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic        level;
    logic        rise;
    logic        fall;

    always_comb begin
        st_d = st_q;
        if (SYNC_STAGES > 1) begin
            st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_in};
        end else begin
            st_d.sync[0] = pin_in;
        end
        st_d.prev = st_q.sync[LAST];

        level = st_q.sync[LAST];
        rise  = level & ~st_q.prev;
        fall  = ~level & st_q.prev;
        unique case (edge_sel)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_ANY:  hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a disabled selector never produces a capture event
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == EDGE_OFF) |-> !hit);

endmodule

// File: rtl/bic_store.sv
module bic_store #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_cnt,
    input  logic          hit,
    input  logic          novw_en,
    input  logic          latch_stb,
    input  logic          cap_rd,
    input  logic          hold_rd,
    output logic [TW-1:0] cap_data,
    output logic [TW-1:0] hold_data,
    output logic          cap_full,
    output logic          hold_full,
    output logic          accept
);
    typedef struct packed {
        logic [TW-1:0] cap;
        logic [TW-1:0] hold;
        logic          cap_full;
        logic          hold_full;
    } store_state_t;

    store_state_t st_d, st_q;
    logic         move;

    always_comb begin
        st_d   = st_q;
        accept = hit & (~novw_en | ~st_q.cap_full);
        move   = latch_stb & st_q.cap_full;

        if (hold_rd) st_d.hold_full = 1'b0;
        if (move) begin
            st_d.hold      = st_q.cap;
            st_d.hold_full = 1'b1;
        end

        if (cap_rd || move) st_d.cap_full = 1'b0;
        if (accept) begin
            st_d.cap      = timer_cnt;
            st_d.cap_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_data  = st_q.cap;
    assign hold_data = st_q.hold;
    assign cap_full  = st_q.cap_full;
    assign hold_full = st_q.hold_full;

    // R4: a latch with a pending capture fills the holding register
    p_latch_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_stb && cap_full) |=> (hold_full && hold_data == $past(cap_data)));

    // R8: blocked capture leaves the stored value untouched
    p_novw_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (novw_en && cap_full && hit) |=> (cap_data == $past(cap_data)));

    // R7: with overwrite allowed every edge lands
    p_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !novw_en) |=> (cap_full && cap_data == $past(timer_cnt)));

    // R6: only a read empties the holding register
    p_hold_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !hold_rd) |=> hold_full);

endmodule

// File: rtl/bic_flag.sv
module bic_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R10: sticky until cleared, set takes priority
    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

endmodule

// File: rtl/bic_channel.sv
module bic_channel
    import bic_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_cnt,
    input  logic          pin_in,
    input  logic [1:0]    edge_sel,
    input  logic          novw_en,
    input  logic          latch_stb,
    input  logic          cap_rd,
    input  logic          hold_rd,
    input  logic          flag_clr,
    output logic [TW-1:0] cap_data,
    output logic [TW-1:0] hold_data,
    output logic          cap_full,
    output logic          hold_full,
    output logic          cap_flag
);
    logic       hit;
    logic       accept;
    edge_mode_e mode;

    assign mode = edge_mode_e'(edge_sel);

    bic_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .edge_sel (mode),
        .hit      (hit)
    );

    bic_store #(.TW(TW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_cnt (timer_cnt),
        .hit       (hit),
        .novw_en   (novw_en),
        .latch_stb (latch_stb),
        .cap_rd    (cap_rd),
        .hold_rd   (hold_rd),
        .cap_data  (cap_data),
        .hold_data (hold_data),
        .cap_full  (cap_full),
        .hold_full (hold_full),
        .accept    (accept)
    );

    bic_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (accept),
        .clr_i  (flag_clr),
        .flag_o (cap_flag)
    );

endmodule

// File: tb/sim_bic_channel.sv
module sim_bic_channel;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] timer_cnt = '0;
    logic          pin_in = 1'b0;
    logic [1:0]    edge_sel = 2'b00;
    logic          novw_en = 1'b0;
    logic          latch_stb = 1'b0;
    logic          cap_rd = 1'b0;
    logic          hold_rd = 1'b0;
    logic          flag_clr = 1'b0;
    logic [TW-1:0] cap_data, hold_data;
    logic          cap_full, hold_full, cap_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bic_channel #(.TW(TW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .timer_cnt(timer_cnt), .pin_in(pin_in),
        .edge_sel(edge_sel), .novw_en(novw_en), .latch_stb(latch_stb),
        .cap_rd(cap_rd), .hold_rd(hold_rd), .flag_clr(flag_clr),
        .cap_data(cap_data), .hold_data(hold_data), .cap_full(cap_full),
        .hold_full(hold_full), .cap_flag(cap_flag)
    );

    // sel, novw, pin, timer, exp_full, exp_cap, exp_flag
    localparam int VW = 38;
    localparam logic [VW-1:0] VEC [8] = '{
        {2'b01, 1'b0, 1'b1, 16'h1111, 1'b1, 16'h1111, 1'b1},
        {2'b01, 1'b0, 1'b0, 16'h2222, 1'b1, 16'h1111, 1'b0},
        {2'b10, 1'b0, 1'b1, 16'h3333, 1'b1, 16'h1111, 1'b0},
        {2'b10, 1'b0, 1'b0, 16'h4444, 1'b1, 16'h4444, 1'b1},
        {2'b11, 1'b0, 1'b1, 16'h5555, 1'b1, 16'h5555, 1'b1},
        {2'b11, 1'b1, 1'b0, 16'h6666, 1'b1, 16'h5555, 1'b0},
        {2'b00, 1'b0, 1'b1, 16'h7777, 1'b1, 16'h5555, 1'b0},
        {2'b11, 1'b0, 1'b0, 16'h8888, 1'b1, 16'h8888, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cap_full", TW'(cap_full), 0);
        check("R1 hold_full", TW'(hold_full), 0);
        check("R1 cap_flag", TW'(cap_flag), 0);
        check("R1 cap_data", cap_data, 0);
        check("R1 hold_data", hold_data, 0);
        rst_n = 1'b1;
        tick();

        // R2/R7/R8 vector walk
        for (int i = 0; i < 8; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            edge_sel  = v[37:36];
            novw_en   = v[35];
            pin_in    = v[34];
            timer_cnt = v[33:18];
            repeat (4) tick();
            check($sformatf("R2/R7/R8 vec%0d full", i), TW'(cap_full), TW'(v[17]));
            check($sformatf("R2/R7/R8 vec%0d cap", i), cap_data, v[16:1]);
            check($sformatf("R10 vec%0d flag", i), TW'(cap_flag), TW'(v[0]));
            pulse_clr();
            check($sformatf("R10 vec%0d cleared", i), TW'(cap_flag), 0);
        end

        // R3 latency: rising edge, timer A0A0
        novw_en = 1'b0; edge_sel = 2'b01; timer_cnt = 16'hA0A0; pin_in = 1'b1;
        tick(); tick();
        check("R3 not after edge 2", cap_data, 16'h8888);
        tick();
        check("R3 after edge 3", cap_data, 16'hA0A0);
        pulse_clr();

        // R6 capture read
        cap_rd = 1'b1; tick(); cap_rd = 1'b0;
        check("R6 cap_full after read", TW'(cap_full), 0);

        // R5 latch with empty capture
        latch_stb = 1'b1; tick(); latch_stb = 1'b0;
        check("R5 hold_full", TW'(hold_full), 0);
        check("R5 hold_data", hold_data, 0);

        // R4 latch with pending capture
        edge_sel = 2'b11; timer_cnt = 16'hB0B0; pin_in = 1'b0;
        repeat (4) tick();
        latch_stb = 1'b1; tick(); latch_stb = 1'b0;
        check("R4 hold_data", hold_data, 16'hB0B0);
        check("R4 hold_full", TW'(hold_full), 1);
        check("R4 cap_full", TW'(cap_full), 0);

        // R8 accept when empty under no-overwrite
        novw_en = 1'b1; timer_cnt = 16'hC0C0; pin_in = 1'b1;
        repeat (4) tick();
        check("R8 accept empty", cap_data, 16'hC0C0);
        check("R8 full", TW'(cap_full), 1);
        pulse_clr();

        // R11 latch and capture same cycle
        novw_en = 1'b0;
        tick();
        timer_cnt = 16'hD0D0; pin_in = 1'b0;
        tick(); tick();
        latch_stb = 1'b1; tick(); latch_stb = 1'b0;
        check("R11 hold old", hold_data, 16'hC0C0);
        check("R11 cap new", cap_data, 16'hD0D0);
        check("R11 cap_full", TW'(cap_full), 1);

        // R9 read and capture same cycle
        tick();
        timer_cnt = 16'hE0E0; pin_in = 1'b1;
        tick(); tick();
        cap_rd = 1'b1;
        check("R9 read old value", cap_data, 16'hD0D0);
        tick(); cap_rd = 1'b0;
        check("R9 new value", cap_data, 16'hE0E0);
        check("R9 full", TW'(cap_full), 1);

        // R6 hold read
        hold_rd = 1'b1; tick(); hold_rd = 1'b0;
        check("R6 hold_full cleared", TW'(hold_full), 0);
        check("R6 cap_full kept", TW'(cap_full), 1);

        // R10 set wins over clear
        pulse_clr();
        check("R10 cleared", TW'(cap_flag), 0);
        timer_cnt = 16'hF0F0; pin_in = 1'b0;
        tick(); tick();
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        check("R10 set wins", TW'(cap_flag), 1);
        pulse_clr();
        check("R10 clear alone", TW'(cap_flag), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule